// File: doc/BRIEF.md
# Multi-Port GPIO Register Bank

This block holds the control and status registers for six byte-wide general-purpose I/O ports. A processor reaches it over a simple byte-wide memory-mapped bus with a single-cycle read path. Each port owns a group of three registers: a read-only view of the pin levels, a stored output value, and a per-pin drive enable. The block drives the pad output values and drive enables, and it samples the incoming pad levels through a two-flop synchronizer.

Input visibility is gated per pin by an externally supplied input-enable vector. Not every port has all eight pins. Port 0 has four pins and ports 4 and 5 have six. Missing pins read as zero and cannot be set. A stored output value may be written at any time, but it only reaches the pad while that pin's drive enable is set.

Top module: `gpio_port_bank`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stored output bit and every drive-enable bit is cleared, so `pin_out` and `pin_oe` are all zero from the next cycle.
- R2: The register group of port p (0 to 5) starts at byte address 0x5200 + 0x10*p. Offset 0 is the pin-level register, offset 1 is the output-value register and offset 2 is the drive-enable register. Bit b of port p maps to pin index p*8+b of the `pin_*` vectors.
- R3: When a pin's input enable is 1, a read of offset 0 returns that pin's level as sampled two clock edges earlier (1 high, 0 low). This also holds while the pin's drive enable is 1.
- R4: When a pin's input enable is 0, that bit of an offset-0 read is 0.
- R5: A write to offset 0 changes no register and no pin output.
- R6: An output-value write is stored at the next edge and reads back from offset 1. `pin_out` carries the stored bit only while its drive-enable bit is 1 and is 0 otherwise. The stored value is kept while the drive is disabled.
- R7: A drive-enable write is stored at the next edge, reads back from offset 2 and appears on `pin_oe`. Without a write, `pin_oe` does not change.
- R8: Port 0 implements bits 3:0 and ports 4 and 5 implement bits 5:0. In all three registers the other bits read 0, ignore writes and keep their pin outputs at 0.
- R9: Reads of offsets 3 to 15 inside a group, and of addresses outside 0x5200 to 0x525F, return 0x00. Writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 16 | Byte address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (combinational) |
| pin_in | input | 48 | Pad input levels, port p in bits p*8+7 : p*8 |
| pin_ien | input | 48 | Per-pin input enable |
| pin_out | output | 48 | Pad output values |
| pin_oe | output | 48 | Pad drive enables |

## Verification
The bench builds the block with its default parameters: six ports, 0x5200 base, a 16-byte group stride and a two-stage synchronizer. With these values the narrow ports 0, 4 and 5 sit next to full-width ports, so the reserved-bit masking of every register can be checked against neighbours that have no masking. The default stride leaves offsets 3 to 15 unmapped in each group, so the unmapped reads can be exercised both inside a group and past the last port. The two-stage synchronizer fixes the latency from a pad change to a visible read at two edges, and the bench waits for that count before it checks a read.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

   typedef enum logic [1:0] {
      REG_IN   = 2'd0,
      REG_OUT  = 2'd1,
      REG_OE   = 2'd2,
      REG_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/gpio_addr_dec.sv
module gpio_addr_dec
   import gpio_bank_pkg::*;
#(
   parameter int                 ADDR_W    = 16,
   parameter int                 NUM_PORTS = 6,
   parameter int                 STRIDE_LG = 4,
   parameter logic [ADDR_W-1:0]  BASE_ADDR = 16'h5200,
   localparam int                IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic [ADDR_W-1:0] addr,
   output logic              hit,
   output logic [IDX_W-1:0]  port_idx,
   output reg_sel_e          sel
);

   logic [ADDR_W-1:0]    offs;
   logic [ADDR_W-1:0]    grp;
   logic [STRIDE_LG-1:0] sub;
   logic                 in_range;

   always_comb begin
      offs     = addr - BASE_ADDR;
      grp      = offs >> STRIDE_LG;
      sub      = offs[STRIDE_LG-1:0];
      in_range = (addr >= BASE_ADDR) && (grp < ADDR_W'(NUM_PORTS));
      port_idx = grp[IDX_W-1:0];
      case (sub)
         STRIDE_LG'(0): sel = REG_IN;
         STRIDE_LG'(1): sel = REG_OUT;
         STRIDE_LG'(2): sel = REG_OE;
         default:       sel = REG_NONE;
      endcase
      hit = in_range && (sel != REG_NONE);
   end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
   parameter int W      = 48,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] st [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) st[s] <= '0;
            else        st[s] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (!rst_n) st[s] <= '0;
            else        st[s] <= st[s-1];
         end
      end
   end

   assign q = st[STAGES-1];

endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
   parameter int           W    = 8,
   parameter logic [W-1:0] MASK = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_out,
   input  logic         wr_oe,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] in_sync,
   input  logic [W-1:0] ien,
   output logic [W-1:0] out_q,
   output logic [W-1:0] oe_q,
   output logic [W-1:0] in_rd
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
         oe_q  <= '0;
      end else begin
         if (wr_out) out_q <= wdata & MASK;
         if (wr_oe)  oe_q  <= wdata & MASK;
      end
   end

   assign in_rd = in_sync & ien & MASK;

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
   import gpio_bank_pkg::*;
#(
   parameter int                          ADDR_W      = 16,
   parameter int                          PORT_W      = 8,
   parameter int                          NUM_PORTS   = 6,
   parameter int                          STRIDE_LG   = 4,
   parameter int                          SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0]           BASE_ADDR   = 16'h5200,
   parameter logic [NUM_PORTS*PORT_W-1:0] PORT_MASKS  = 48'h3F3F_FFFF_FF0F,
   localparam int                         PIN_W       = NUM_PORTS * PORT_W,
   localparam int                         IDX_W       = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [PORT_W-1:0] bus_wdata,
   output logic [PORT_W-1:0] bus_rdata,
   input  logic [PIN_W-1:0]  pin_in,
   input  logic [PIN_W-1:0]  pin_ien,
   output logic [PIN_W-1:0]  pin_out,
   output logic [PIN_W-1:0]  pin_oe
);

   if (STRIDE_LG < 2) begin : g_bad_stride
      $error("stride must hold three registers");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("synchronizer needs at least two stages");
   end
   if (NUM_PORTS < 1 || PORT_W < 1) begin : g_bad_size
      $error("empty port bank");
   end
   if ((NUM_PORTS << STRIDE_LG) + int'(BASE_ADDR) > (1 << ADDR_W)) begin : g_bad_map
      $error("register window exceeds address space");
   end

   logic              hit;
   logic [IDX_W-1:0]  port_idx;
   reg_sel_e          sel;
   logic [PIN_W-1:0]  in_sync;
   logic [PORT_W-1:0] in_v  [NUM_PORTS];
   logic [PORT_W-1:0] out_v [NUM_PORTS];
   logic [PORT_W-1:0] oe_v  [NUM_PORTS];

   gpio_addr_dec #(
      .ADDR_W    (ADDR_W),
      .NUM_PORTS (NUM_PORTS),
      .STRIDE_LG (STRIDE_LG),
      .BASE_ADDR (BASE_ADDR)
   ) dec_i (
      .addr     (bus_addr),
      .hit      (hit),
      .port_idx (port_idx),
      .sel      (sel)
   );

   gpio_sync #(
      .W      (PIN_W),
      .STAGES (SYNC_STAGES)
   ) sync_i (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pin_in),
      .q     (in_sync)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      logic wr_out;
      logic wr_oe;

      assign wr_out = bus_we && hit && (sel == REG_OUT) && (port_idx == IDX_W'(p));
      assign wr_oe  = bus_we && hit && (sel == REG_OE)  && (port_idx == IDX_W'(p));

      gpio_port #(
         .W    (PORT_W),
         .MASK (PORT_MASKS[p*PORT_W +: PORT_W])
      ) port_i (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_out  (wr_out),
         .wr_oe   (wr_oe),
         .wdata   (bus_wdata),
         .in_sync (in_sync[p*PORT_W +: PORT_W]),
         .ien     (pin_ien[p*PORT_W +: PORT_W]),
         .out_q   (out_v[p]),
         .oe_q    (oe_v[p]),
         .in_rd   (in_v[p])
      );

      assign pin_out[p*PORT_W +: PORT_W] = out_v[p] & oe_v[p];
      assign pin_oe[p*PORT_W +: PORT_W]  = oe_v[p];
   end

   always_comb begin
      bus_rdata = '0;
      if (hit) begin
         case (sel)
            REG_IN:  bus_rdata = in_v[port_idx];
            REG_OUT: bus_rdata = out_v[port_idx];
            REG_OE:  bus_rdata = oe_v[port_idx];
            default: bus_rdata = '0;
         endcase
      end
   end

endmodule

module gpio_port_bank_chk #(
   parameter int                          ADDR_W     = 16,
   parameter int                          PORT_W     = 8,
   parameter int                          NUM_PORTS  = 6,
   parameter int                          STRIDE_LG  = 4,
   parameter logic [ADDR_W-1:0]           BASE_ADDR  = 16'h5200,
   parameter logic [NUM_PORTS*PORT_W-1:0] PORT_MASKS = 48'h3F3F_FFFF_FF0F,
   localparam int                         PIN_W      = NUM_PORTS * PORT_W
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_we,
   input logic [PORT_W-1:0] bus_wdata,
   input logic [PORT_W-1:0] bus_rdata,
   input logic [PIN_W-1:0]  pin_ien,
   input logic [PIN_W-1:0]  pin_out,
   input logic [PIN_W-1:0]  pin_oe
);

   logic [ADDR_W-1:0] c_offs;
   logic [ADDR_W-1:0] c_grp;
   int                c_sub;
   int                c_idx;
   logic              c_hit;
   logic [PORT_W-1:0] c_mask;
   logic [PORT_W-1:0] c_ien;

   always_comb begin
      c_offs = bus_addr - BASE_ADDR;
      c_grp  = c_offs >> STRIDE_LG;
      c_sub  = int'(c_offs & ADDR_W'((1 << STRIDE_LG) - 1));
      c_hit  = (bus_addr >= BASE_ADDR) && (c_grp < ADDR_W'(NUM_PORTS)) && (c_sub < 3);
      c_idx  = c_hit ? int'(c_grp) : 0;
      c_mask = PORT_MASKS[c_idx*PORT_W +: PORT_W];
      c_ien  = pin_ien[c_idx*PORT_W +: PORT_W];
   end

   logic              oe_wr_q;
   int                oe_idx_q;
   logic [PORT_W-1:0] oe_exp_q;

   always_ff @(posedge clk) begin
      oe_wr_q  <= rst_n && bus_we && c_hit && (c_sub == 2);
      oe_idx_q <= c_idx;
      oe_exp_q <= bus_wdata & c_mask;
   end

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      !rst_n |=> (pin_out == '0) && (pin_oe == '0));

   // R7
   oe_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_wr_q |-> (pin_oe[oe_idx_q*PORT_W +: PORT_W] == oe_exp_q));

   // R7
   oe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_we |=> $stable(pin_oe));

   // R9
   unmapped_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_hit |-> (bus_rdata == '0));

   // R8
   reserved_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_hit |-> ((bus_rdata & ~c_mask) == '0));

   // R4
   in_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_hit && (c_sub == 0)) |-> ((bus_rdata & ~c_ien) == '0));

endmodule

bind gpio_port_bank gpio_port_bank_chk #(
   .ADDR_W     (ADDR_W),
   .PORT_W     (PORT_W),
   .NUM_PORTS  (NUM_PORTS),
   .STRIDE_LG  (STRIDE_LG),
   .BASE_ADDR  (BASE_ADDR),
   .PORT_MASKS (PORT_MASKS)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .pin_ien   (pin_ien),
   .pin_out   (pin_out),
   .pin_oe    (pin_oe)
);

// File: tb/gpio_port_bank_tb_top.sv
module gpio_port_bank_tb_top;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic [47:0] pin_in = '0;
   logic [47:0] pin_ien = '0;
   logic [47:0] pin_out;
   logic [47:0] pin_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [7:0] m_out [6];
   logic [7:0] m_oe  [6];

   typedef struct {
      logic [7:0] exp;
      string      tag;
   } rd_item_t;

   rd_item_t rd_q [$];
   event     rd_ev;

   always #(CLK_P/2) clk = ~clk;

   gpio_port_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pin_in    (pin_in),
      .pin_ien   (pin_ien),
      .pin_out   (pin_out),
      .pin_oe    (pin_oe)
   );

   function automatic logic [7:0] pmask(int p);
      if (p == 0) return 8'h0F;
      if (p >= 4) return 8'h3F;
      return 8'hFF;
   endfunction

   function automatic logic [15:0] reg_addr(int p, int off);
      return 16'h5200 + 16'(p * 16) + 16'(off);
   endfunction

   task automatic check8(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   task automatic check48(string tag, logic [47:0] act, logic [47:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %012h expected %012h", tag, act, exp);
      end
   endtask

   // monitor: pops expected read items and compares with the bus
   initial begin
      forever begin
         @(rd_ev);
         while (rd_q.size() > 0) begin
            rd_item_t it;
            it = rd_q.pop_front();
            check8(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic bus_rd(logic [15:0] a, logic [7:0] exp, string tag);
      rd_item_t it;
      @(negedge clk);
      bus_addr = a;
      bus_we   = 1'b0;
      #(CLK_P/4);
      it.exp = exp;
      it.tag = tag;
      rd_q.push_back(it);
      ->rd_ev;
   endtask

   task automatic bus_wr(logic [15:0] a, logic [7:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      for (int p = 0; p < 6; p++) begin
         if (a == reg_addr(p, 1)) m_out[p] = d & pmask(p);
         if (a == reg_addr(p, 2)) m_oe[p]  = d & pmask(p);
      end
   endtask

   task automatic chk_pins(string tag);
      logic [47:0] eo;
      logic [47:0] ee;
      #(CLK_P/4);
      for (int p = 0; p < 6; p++) begin
         eo[p*8 +: 8] = m_out[p] & m_oe[p];
         ee[p*8 +: 8] = m_oe[p];
      end
      check48({tag, " pin_out"}, pin_out, eo);
      check48({tag, " pin_oe"}, pin_oe, ee);
   endtask

   task automatic rd_all_regs(string tag);
      for (int p = 0; p < 6; p++) begin
         bus_rd(reg_addr(p, 1), m_out[p], {tag, " out"});
         bus_rd(reg_addr(p, 2), m_oe[p], {tag, " oe"});
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 20000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [47:0] pat;
      for (int p = 0; p < 6; p++) begin
         m_out[p] = '0;
         m_oe[p]  = '0;
      end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk_pins("R1 reset");
      rst_n = 1'b1;
      rd_all_regs("R1 R2 after reset");

      // R6 R8: output values stored while drive disabled
      for (int p = 0; p < 6; p++) bus_wr(reg_addr(p, 1), 8'hFF);
      chk_pins("R6 drive off");
      rd_all_regs("R6 R8 stored");

      // R7 R8: enable drives
      for (int p = 0; p < 6; p++) bus_wr(reg_addr(p, 2), 8'hFF);
      chk_pins("R7 R8 drive on");
      rd_all_regs("R7 R8 readback");

      // R6: new patterns with partial enables
      for (int p = 0; p < 6; p++) bus_wr(reg_addr(p, 1), 8'hA5 ^ 8'(p * 17));
      bus_wr(reg_addr(2, 2), 8'h0F);
      bus_wr(reg_addr(5, 2), 8'h30);
      chk_pins("R6 partial drive");
      rd_all_regs("R6 pattern");

      // R3: pin levels with input enable on, drives on
      pat     = 48'hC35A_96E1_7B2D;
      pin_ien = '1;
      pin_in  = pat;
      repeat (3) @(negedge clk);
      for (int p = 0; p < 6; p++)
         bus_rd(reg_addr(p, 0), pat[p*8 +: 8] & pmask(p), "R3 R8 pin read");

      // R3: two-edge latency, new level not visible after one edge
      @(negedge clk);
      pin_in[15:8] = ~pat[15:8];
      #(CLK_P/4);
      bus_addr = reg_addr(1, 0);
      @(negedge clk);
      #(CLK_P/4);
      check8("R3 one edge old", bus_rdata, pat[15:8]);
      @(negedge clk);
      #(CLK_P/4);
      check8("R3 two edges new", bus_rdata, ~pat[15:8]);

      // R4: input enable gating
      pin_in  = pat;
      pin_ien = 48'h0F0F_00FF_F0AA;
      repeat (3) @(negedge clk);
      for (int p = 0; p < 6; p++)
         bus_rd(reg_addr(p, 0), pat[p*8 +: 8] & pin_ien[p*8 +: 8] & pmask(p), "R4 gated read");

      // R5: write to pin-level register ignored
      for (int p = 0; p < 6; p++) bus_wr(reg_addr(p, 0), 8'h5A);
      chk_pins("R5 write in");
      rd_all_regs("R5 regs kept");
      bus_rd(reg_addr(3, 0), pat[31:24] & pin_ien[31:24], "R5 in read");

      // R9: unmapped reads and writes
      bus_rd(16'h5203, 8'h00, "R9 offset 3");
      bus_rd(16'h521F, 8'h00, "R9 offset 15");
      bus_rd(16'h5260, 8'h00, "R9 past end");
      bus_rd(16'h51FF, 8'h00, "R9 below base");
      bus_rd(16'h0201, 8'h00, "R9 far");
      bus_wr(16'h5203, 8'hFF);
      bus_wr(16'h5260, 8'hFF);
      bus_wr(16'h5261, 8'hFF);
      bus_wr(16'h51F1, 8'hFF);
      chk_pins("R9 stray writes");
      rd_all_regs("R9 regs kept");

      // R1: reset in mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      for (int p = 0; p < 6; p++) begin
         m_out[p] = '0;
         m_oe[p]  = '0;
      end
      chk_pins("R1 mid reset");
      rst_n = 1'b1;
      rd_all_regs("R1 mid reset");

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule